// File: doc/BRIEF.md
# Register-Mapped Byte SPI Master

This block is an SPI master that a processor drives through a small 32-bit register bus. Software picks one of four slaves, sets clock polarity, clock phase and a clock divider, and writes a byte to the transmit register. The engine then shifts eight bits out on MOSI, most significant bit first, and samples eight bits from MISO at the same time. When the byte is done, the received value sits in the receive register. Completion can be polled in the control word or taken as an interrupt through a status/mask pair.

Only one lane and one byte at a time are supported. The lane-count, byte-length, FIFO and DMA fields of the configuration word are stored and read back, but they do not change what the engine does. A flush command clears the receive register. A soft-reset command stops a byte that is in flight. Both commands clear themselves.

Top module: `spi_byte_master`

## Requirements
- R1: The registers sit at these byte offsets: control 0x00, configuration 0x04, transmit 0x08, receive 0x0C, interrupt status 0x28, interrupt mask 0x2C. A read returns its word on bus_rdata one clock after the address is presented. The configuration word reads back exactly as written, except bits 9 and 16.
- R2: Control bits 19:16 drive spi_cs[3:0], active high. If more than one of those bits is written as 1, only the lowest set bit is kept. Writing zero releases every chip select.
- R3: Writing the transmit register while the engine is idle starts one 8-bit transfer, MSB first. When it ends, receive bits 7:0 hold the byte sampled from MISO.
- R4: Configuration bit 7 (CPOL) sets the idle level of SCLK. Configuration bit 6 (CPHA) selects the sampling edge. With CPHA 0, MISO is sampled on the leading edge and MOSI changes on the trailing edge. With CPHA 1, MOSI changes on the leading edge and MISO is sampled on the trailing edge.
- R5: Configuration bits 4:0 hold a divider P. Each SCLK half-period lasts P core clocks, and P = 0 acts as 1. A byte therefore takes 16 half-periods.
- R6: A write to the transmit register while a byte is still shifting is ignored. The byte in flight and the data it returns are unchanged.
- R7: Control bit 1 reads 1 while the engine is idle. Control bit 0 is set when a byte completes and cleared when the next byte starts.
- R8: Interrupt status bit 0 (done) and bit 1 (ready) are both set when a byte completes. Each bit is cleared by writing 1 to it, and writing 0 leaves it unchanged.
- R9: irq is the OR of interrupt status ANDed bit by bit with interrupt mask bits 1:0, registered. A mask of 0 keeps irq low.
- R10: Writing 1 to configuration bit 9 clears the receive register. The bit then reads back as 0.
- R11: Writing 1 to configuration bit 16 returns the engine to idle. SCLK goes back to its CPOL level, no completion is flagged, and the bit then reads back as 0.
- R12: Configuration bits 11:10, 5, 17, 18, 19 and 20 are stored but have no effect. A transfer runs single-lane, single-byte whatever their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the address |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the slave |
| spi_miso | input | 1 | Serial data from the slave |
| spi_cs | output | 4 | Active-high chip selects |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: an 8-bit address, four chip selects, a 5-bit divider and 8-bit bytes. With a 5-bit divider, every divider value from 0 up to the maximum of 31 can be tried within the cycle budget, so the bench covers the zero-treated-as-one case, the fastest setting and the slowest. Four chip selects keep every one-hot choice and multi-bit collapse pattern small enough to try directly. A bench slave model works independently in all four clock modes and swaps bytes with the master.

// File: rtl/spi_byte_pkg.sv
package spi_byte_pkg;
  localparam logic [7:0] OFS_CTRL  = 8'h00;
  localparam logic [7:0] OFS_CFG   = 8'h04;
  localparam logic [7:0] OFS_TXD   = 8'h08;
  localparam logic [7:0] OFS_RXD   = 8'h0C;
  localparam logic [7:0] OFS_ISTAT = 8'h28;
  localparam logic [7:0] OFS_IMASK = 8'h2C;

  localparam int CS_LSB    = 16;
  localparam int CFG_CPHA  = 6;
  localparam int CFG_CPOL  = 7;
  localparam int CFG_FLUSH = 9;
  localparam int CFG_SRST  = 16;
  localparam int ST_DONE   = 0;
  localparam int ST_READY  = 1;
  localparam int ST_W      = 2;
endpackage

// File: rtl/spi_half_tick.sv
module spi_half_tick #(
  parameter int PSC_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [PSC_W-1:0] psc,
  output logic             tick
);
  logic [PSC_W-1:0] cnt;
  logic [PSC_W-1:0] lim;

  // divider of zero behaves as one
  assign lim  = (psc == '0) ? '0 : psc - 1'b1;
  assign tick = en && (cnt == lim);

  always_ff @(posedge clk) begin
    if (rst || !en) cnt <= '0;
    else if (tick)  cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end

  // R5: consecutive ticks only when the half-period is one clock
  assert_tick_gap_R5: assert property (@(posedge clk) disable iff (rst)
    (tick && $stable(psc)) |=> (!tick || lim == '0 || !en));
endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
  parameter int PSC_W  = 5,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              srst,
  input  logic              cpol,
  input  logic              cpha,
  input  logic [PSC_W-1:0]  psc,
  input  logic              start,
  input  logic [BYTE_W-1:0] din,
  input  logic              miso,
  output logic              busy,
  output logic              done,
  output logic [BYTE_W-1:0] rx,
  output logic              sclk,
  output logic              mosi
);
  localparam int EDGES = 2 * BYTE_W;
  localparam int IDX_W = $clog2(EDGES);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(EDGES - 1);

  logic              tick;
  logic [IDX_W-1:0]  idx;
  logic [BYTE_W-1:0] txsr;
  logic              sample_edge;

  spi_half_tick #(.PSC_W(PSC_W)) u_tick (
    .clk (clk),
    .rst (rst),
    .en  (busy),
    .psc (psc),
    .tick(tick)
  );

  // even edge index is the leading edge; phase flips which one samples
  assign sample_edge = ~idx[0] ^ cpha;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      done <= 1'b0;
      idx  <= '0;
      txsr <= '0;
      rx   <= '0;
      sclk <= 1'b0;
      mosi <= 1'b0;
    end else if (srst) begin
      busy <= 1'b0;
      done <= 1'b0;
      idx  <= '0;
      sclk <= cpol;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        sclk <= cpol;
        idx  <= '0;
        if (start) begin
          busy <= 1'b1;
          if (!cpha) begin
            mosi <= din[BYTE_W-1];
            txsr <= {din[BYTE_W-2:0], 1'b0};
          end else begin
            txsr <= din;
          end
        end
      end else if (tick) begin
        sclk <= ~sclk;
        idx  <= idx + 1'b1;
        if (sample_edge) begin
          rx <= {rx[BYTE_W-2:0], miso};
        end else if (idx != LAST) begin
          mosi <= txsr[BYTE_W-1];
          txsr <= {txsr[BYTE_W-2:0], 1'b0};
        end
        if (idx == LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // R6: a start request during a byte does not disturb the edge count
  assert_no_restart_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !tick && !srst) |=> (idx == $past(idx)));
  // R5: SCLK only moves on a divider tick while shifting
  assert_sclk_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (busy && !tick && !srst) |=> $stable(sclk));
  // R4: idle SCLK rests at the polarity level
  assert_idle_level_R4: assert property (@(posedge clk) disable iff (rst)
    (!busy && $past(!busy) && $stable(cpol)) |-> (sclk == cpol));
  // R11: soft reset leaves the engine idle with no completion
  assert_srst_idle_R11: assert property (@(posedge clk) disable iff (rst)
    srst |=> (!busy && !done));
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
  import spi_byte_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int NUM_CS = 4,
  parameter int PSC_W  = 5,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic [NUM_CS-1:0] spi_cs,
  output logic              irq
);
  logic [DATA_W-1:0] cfg_q;
  logic [NUM_CS-1:0] cs_q;
  logic              done_q;
  logic [BYTE_W-1:0] rxd_q;
  logic [ST_W-1:0]   istat_q;
  logic [ST_W-1:0]   imask_q;

  logic              wr_ctrl, wr_cfg, wr_txd, wr_istat, wr_imask;
  logic              eng_busy, eng_done;
  logic [BYTE_W-1:0] eng_rx;
  logic [NUM_CS-1:0] cs_req;
  logic [ST_W-1:0]   st_clr;

  assign wr_ctrl  = bus_we && (bus_addr == ADDR_W'(OFS_CTRL));
  assign wr_cfg   = bus_we && (bus_addr == ADDR_W'(OFS_CFG));
  assign wr_txd   = bus_we && (bus_addr == ADDR_W'(OFS_TXD));
  assign wr_istat = bus_we && (bus_addr == ADDR_W'(OFS_ISTAT));
  assign wr_imask = bus_we && (bus_addr == ADDR_W'(OFS_IMASK));

  // keep only the lowest requested select
  assign cs_req = bus_wdata[CS_LSB +: NUM_CS] & (~bus_wdata[CS_LSB +: NUM_CS] + 1'b1);
  assign st_clr = wr_istat ? bus_wdata[ST_W-1:0] : '0;

  spi_byte_shifter #(.PSC_W(PSC_W), .BYTE_W(BYTE_W)) u_shift (
    .clk  (clk),
    .rst  (rst),
    .srst (cfg_q[CFG_SRST]),
    .cpol (cfg_q[CFG_CPOL]),
    .cpha (cfg_q[CFG_CPHA]),
    .psc  (cfg_q[PSC_W-1:0]),
    .start(wr_txd),
    .din  (bus_wdata[BYTE_W-1:0]),
    .miso (spi_miso),
    .busy (eng_busy),
    .done (eng_done),
    .rx   (eng_rx),
    .sclk (spi_sclk),
    .mosi (spi_mosi)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q   <= '0;
      cs_q    <= '0;
      done_q  <= 1'b0;
      rxd_q   <= '0;
      istat_q <= '0;
      imask_q <= '0;
      irq     <= 1'b0;
    end else begin
      if (wr_cfg) begin
        cfg_q <= bus_wdata;
      end else begin
        cfg_q[CFG_FLUSH] <= 1'b0;
        cfg_q[CFG_SRST]  <= 1'b0;
      end
      if (wr_ctrl)  cs_q    <= cs_req;
      if (wr_imask) imask_q <= bus_wdata[ST_W-1:0];

      if (wr_txd && !eng_busy) done_q <= 1'b0;
      else if (eng_done)       done_q <= 1'b1;

      if (cfg_q[CFG_FLUSH]) rxd_q <= '0;
      else if (eng_done)    rxd_q <= eng_rx;

      istat_q <= (istat_q & ~st_clr) | {ST_W{eng_done}};
      irq     <= |(istat_q & imask_q);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      bus_rdata <= '0;
      unique case (bus_addr)
        ADDR_W'(OFS_CTRL): begin
          bus_rdata[CS_LSB +: NUM_CS] <= cs_q;
          bus_rdata[ST_READY]         <= ~eng_busy;
          bus_rdata[ST_DONE]          <= done_q;
        end
        ADDR_W'(OFS_CFG):   bus_rdata <= cfg_q;
        ADDR_W'(OFS_RXD):   bus_rdata[BYTE_W-1:0] <= rxd_q;
        ADDR_W'(OFS_ISTAT): bus_rdata[ST_W-1:0]   <= istat_q;
        ADDR_W'(OFS_IMASK): bus_rdata[ST_W-1:0]   <= imask_q;
        default:            bus_rdata <= '0;
      endcase
    end
  end

  assign spi_cs = cs_q;

  // R2: at most one slave selected
  assert_cs_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(spi_cs));
  // R8: write-one clears a status bit when no completion coincides
  assert_w1c_done_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_istat && bus_wdata[ST_DONE] && !eng_done) |=> !istat_q[ST_DONE]);
  // R9: zero mask silences the interrupt
  assert_irq_masked_R9: assert property (@(posedge clk) disable iff (rst)
    (imask_q == '0) |=> !irq);
  // R10: flush command does not persist
  assert_flush_clear_R10: assert property (@(posedge clk) disable iff (rst)
    (cfg_q[CFG_FLUSH] && !wr_cfg) |=> (!cfg_q[CFG_FLUSH] && rxd_q == '0));
  // R7: completion flag drops when a new byte is accepted
  assert_done_restart_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_txd && !eng_busy && !eng_done) |=> !done_q);
endmodule

// File: tb/test_spi_byte_master.sv
`timescale 1ns/1ps
module test_spi_byte_master;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        spi_sclk, spi_mosi;
  logic        spi_miso = 1'b0;
  logic [3:0]  spi_cs;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // bench slave state
  bit       s_active = 0;
  bit       s_cpol = 0, s_cpha = 0;
  bit [7:0] s_tx, s_rx;

  localparam logic [7:0] A_CTRL = 8'h00, A_CFG = 8'h04, A_TXD = 8'h08,
                         A_RXD = 8'h0C, A_ST = 8'h28, A_MSK = 8'h2C;

  always #2.5 clk = ~clk;

  spi_byte_master i_spi_byte_master (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs(spi_cs), .irq(irq)
  );

  // independent SPI slave: samples and drives per mode
  always @(spi_sclk) begin
    if (s_active) begin
      if ((spi_sclk != s_cpol) == !s_cpha) begin
        s_rx = {s_rx[6:0], spi_mosi};
      end else begin
        spi_miso = s_tx[7];
        s_tx = {s_tx[6:0], 1'b0};
      end
    end
  end

  function automatic int half_per(input int psc);
    return (psc == 0) ? 1 : psc;
  endfunction

  function automatic logic [31:0] ctrl_word(input logic [3:0] cs, input bit ready, input bit done);
    return {12'h0, cs, 14'h0, ready, done};
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic slave_arm(input bit pol, input bit pha, input logic [7:0] b);
    s_cpol = pol; s_cpha = pha; s_rx = '0; s_tx = b;
    if (!pha) begin
      spi_miso = b[7];
      s_tx = {b[6:0], 1'b0};
    end else begin
      spi_miso = 1'b0;
    end
    s_active = 1;
  endtask

  task automatic wait_done();
    logic [31:0] v;
    for (int k = 0; k < 3000; k++) begin
      rd(A_CTRL, v);
      if (v[0]) break;
    end
  endtask

  // one full byte exchange with checks
  task automatic xfer(input int mode, input int psc, input logic [31:0] extra,
                      input logic [7:0] tx, input logic [7:0] sb,
                      input bit measure, input bit poke_busy);
    logic [31:0] v;
    bit pol, pha;
    int n;
    pol = mode[1]; pha = mode[0];
    wr(A_CFG, extra | (32'(pol) << 7) | (32'(pha) << 6) | 32'(psc));
    wr(A_ST, 32'h3);
    repeat (2) @(negedge clk);
    slave_arm(pol, pha, sb);
    wr(A_TXD, {24'h0, tx});
    if (poke_busy) begin
      wr(A_TXD, {24'h0, ~tx});
      rd(A_CTRL, v);
      check("R7", "ctrl while busy", v, ctrl_word(spi_cs, 1'b0, 1'b0));
    end
    if (measure) begin
      n = 0;
      while (spi_sclk == pol && n < 100) begin @(negedge clk); n++; end
      check("R5", "first half-period", n, half_per(psc));
      n = 0;
      while (spi_sclk != pol && n < 100) begin @(negedge clk); n++; end
      check("R5", "second half-period", n, half_per(psc));
    end
    wait_done();
    s_active = 0;
    rd(A_RXD, v);
    check("R3", $sformatf("rx byte mode %0d psc %0d", mode, psc), v, {24'h0, sb});
    check(poke_busy ? "R6" : "R4", $sformatf("slave got mode %0d", mode), {24'h0, s_rx}, {24'h0, tx});
    rd(A_CTRL, v);
    check("R7", "ctrl after byte", v, ctrl_word(spi_cs, 1'b1, 1'b1));
    check("R4", "sclk idle level", {31'h0, spi_sclk}, {31'h0, pol});
    rd(A_ST, v);
    check("R8", "status after byte", v, 32'h3);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v;
    int seed;
    seed = $urandom(32'd4711);
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // reset state
    check("R2", "cs after reset", {28'h0, spi_cs}, 32'h0);
    check("R9", "irq after reset", {31'h0, irq}, 32'h0);
    rd(A_CTRL, v);
    check("R7", "ctrl after reset", v, ctrl_word(4'h0, 1'b1, 1'b0));

    // chip select handling
    wr(A_CTRL, 32'h4 << 16);
    check("R2", "single select", {28'h0, spi_cs}, 32'h4);
    wr(A_CTRL, 32'h6 << 16);
    check("R2", "lowest of two", {28'h0, spi_cs}, 32'h2);
    wr(A_CTRL, 32'hF << 16);
    check("R2", "lowest of four", {28'h0, spi_cs}, 32'h1);
    wr(A_CTRL, 32'h0);
    check("R2", "release", {28'h0, spi_cs}, 32'h0);
    wr(A_CTRL, 32'h8 << 16);

    // configuration readback including inert fields
    wr(A_CFG, 32'h001E_0CA3);
    rd(A_CFG, v);
    check("R1", "cfg readback", v, 32'h001E_0CA3);
    rd(A_MSK, v);
    check("R1", "mask reset value", v, 32'h0);

    // directed corners
    xfer(0, 0, 32'h0, 8'hA5, 8'h3C, 1, 0);
    xfer(1, 1, 32'h0, 8'h81, 8'h7E, 1, 0);
    xfer(3, 31, 32'h0, 8'h0F, 8'hF0, 1, 0);
    xfer(2, 3, 32'h0, 8'h55, 8'hAA, 0, 1);
    // inert fields set: lanes=2, byte-length, fifo, dma
    xfer(1, 2, 32'h001E_0820, 8'hC3, 8'h96, 1, 0);
    rd(A_CFG, v);
    check("R12", "inert fields kept", v & 32'h001E_0C20, 32'h001E_0820);

    // random exchanges
    for (int i = 0; i < 12; i++) begin
      xfer(i % 4, $urandom_range(0, 6), 32'h0, 8'($urandom), 8'($urandom) | 8'h01, 1, 0);
    end

    // interrupt masking and write-one-to-clear
    wr(A_MSK, 32'h1);
    repeat (2) @(negedge clk);
    check("R9", "irq done masked in", {31'h0, irq}, 32'h1);
    wr(A_ST, 32'h1);
    repeat (2) @(negedge clk);
    rd(A_ST, v);
    check("R8", "clear done only", v, 32'h2);
    check("R9", "irq after clear", {31'h0, irq}, 32'h0);
    wr(A_MSK, 32'h2);
    repeat (2) @(negedge clk);
    check("R9", "irq on ready", {31'h0, irq}, 32'h1);
    wr(A_ST, 32'h0);
    rd(A_ST, v);
    check("R8", "write zero keeps", v, 32'h2);
    wr(A_MSK, 32'h0);
    repeat (2) @(negedge clk);
    check("R9", "mask zero", {31'h0, irq}, 32'h0);
    wr(A_ST, 32'h2);
    rd(A_ST, v);
    check("R8", "all clear", v, 32'h0);

    // flush clears receive data
    rd(A_RXD, v);
    check("R10", "rx nonzero before flush", {31'h0, v != 0}, 32'h1);
    wr(A_CFG, 32'h0000_0200);
    repeat (2) @(negedge clk);
    rd(A_RXD, v);
    check("R10", "rx after flush", v, 32'h0);
    rd(A_CFG, v);
    check("R10", "flush bit self clears", v, 32'h0);

    // soft reset mid-byte
    wr(A_CFG, 32'h0000_0084);
    wr(A_ST, 32'h3);
    wr(A_TXD, 32'h5A);
    repeat (20) @(negedge clk);
    wr(A_CFG, 32'h0001_0084);
    repeat (3) @(negedge clk);
    rd(A_CTRL, v);
    check("R11", "ctrl after soft reset", v, ctrl_word(4'h8, 1'b1, 1'b0));
    check("R11", "sclk at polarity", {31'h0, spi_sclk}, 32'h1);
    rd(A_ST, v);
    check("R11", "no completion", v, 32'h0);
    rd(A_CFG, v);
    check("R11", "srst bit self clears", v, 32'h0000_0084);
    xfer(2, 2, 32'h0, 8'h9C, 8'h63, 1, 0);

    finished = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule